// File: doc/BRIEF.md
# Serial DAC Input Interface Controller

This block is the serial receive front end for a multiplying digital-to-analog converter. An external host drives three lines: an active-low frame strobe, a serial clock, and a serial data line. All three are synchronized into the system clock domain. Data is sampled on each falling edge of the serial clock, most significant bit first. When a 16-bit word is complete, the block presents a 4-bit control nibble and a 12-bit data field to the converter register, together with a one-cycle update strobe.

Two operating modes exist, and chained mode is the default after reset.

- **Chained mode:** the shift register passes bits through to a serial output, so several converters can share one frame strobe. The word is captured only when the frame strobe returns high.
- **Standalone mode:** the word is captured automatically on the 16th falling serial clock edge. Later edges in that frame are ignored.

A completed frame whose control nibble is 1001 moves the block into standalone mode, where it stays until reset. In either mode, a frame strobe that returns high before 16 bits have arrived abandons the frame.

Top module: `dacif_serial_rx`

## Requirements
- R1: After reset, the block is in the following state:
  - `chain_en` is 1 (chained mode);
  - `upd_strobe`, `ctrl_out`, `data_out` and `ser_out` are all 0.
- R2: Bits are taken on falling edges of `ser_clk`, most significant first. Of the 16-bit word, bits 15..12 drive `ctrl_out` and bits 11..0 drive `data_out`.
- R3: In standalone mode, the word is captured and `upd_strobe` pulses after the 16th falling `ser_clk` edge. This happens while `frame_n` is still low.
- R4: In standalone mode, falling `ser_clk` edges after the 16th in the same frame produce no further strobe and leave the outputs unchanged.
- R5: If `frame_n` rises before 16 bits have been taken, the frame is abandoned. There is no strobe and `ctrl_out`/`data_out` keep their values. This holds in both modes.
- R6: A falling edge of `frame_n` clears the bit count. Bits from an abandoned frame never count toward the next frame.
- R7: In chained mode, no capture occurs at the 16th edge. Bits keep shifting, and the last 16 bits are captured when `frame_n` rises, provided at least 16 bits were taken.
- R8: `ser_out` carries the bit in position 15 of the shift register, which is the bit shifted out next, while in chained mode. `ser_out` is 0 in standalone mode.
- R9: Capturing a word whose control nibble is 4'b1001 clears `chain_en`. Other nibbles leave the mode unchanged, and only reset restores chained mode.
- R10: `upd_strobe` is high for exactly one clock per captured word.
- R11: Falling `ser_clk` edges while `frame_n` is high do not cause a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Active-low frame strobe (asynchronous) |
| ser_clk | input | 1 | Serial clock (asynchronous) |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out for chaining |
| upd_strobe | output | 1 | One-cycle converter register update |
| ctrl_out | output | 4 | Captured control nibble |
| data_out | output | 12 | Captured data field |
| chain_en | output | 1 | 1 = chained mode, 0 = standalone |

## Verification
The hardest situation to reach is a frame that goes stale inside the bit counter. Such a frame is abandoned part-way, and then a short follow-up frame supplies exactly the missing number of bits. That follow-up frame would complete only if the frame start failed to clear the count. The stimulus creates this directly with a 10-bit aborted frame followed by a 6-bit frame, and then with random standalone frames of random length. Pass-through on the serial output is checked by sending 32 bits in one chained frame and comparing `ser_out` against the first word before each edge of the second.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic {
    MODE_SOLO  = 1'b0,
    MODE_CHAIN = 1'b1
  } dac_mode_e;

  localparam logic [3:0] SOLO_CODE_DEFAULT = 4'b1001;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{RST_VAL[b]}};
      else     chain_q <= {chain_q[STAGES-2:0], async_in[b]};
    end

    assign sync_out[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/dacif_shift_core.sv
module dacif_shift_core #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      cnt  <= '0;
    end else begin
      if (shift) word <= {word[WORD_W-2:0], din};
      if (clr) cnt <= '0;
      else if (shift && cnt != FULL) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dacif_frame_ctl.sv
module dacif_frame_ctl
  import dacif_pkg::*;
#(
  parameter int               WORD_W    = 16,
  parameter int               CTRL_W    = 4,
  parameter logic [CTRL_W-1:0] SOLO_CODE = SOLO_CODE_DEFAULT,
  localparam int              DATA_W    = WORD_W - CTRL_W,
  localparam int              CNT_W     = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_lvl,
  input  logic              sclk_lvl,
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  cnt,
  output logic              clr,
  output logic              shift,
  output logic              upd,
  output logic [CTRL_W-1:0] ctrl,
  output logic [DATA_W-1:0] data,
  output logic              chain
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic      frame_q, sclk_q, open_q;
  dac_mode_e mode_q;
  logic      frame_fall, frame_rise, sclk_fall, full;
  logic      load_solo, load_chain, load;

  assign frame_fall = frame_q & ~frame_lvl;
  assign frame_rise = ~frame_q & frame_lvl;
  assign sclk_fall  = sclk_q & ~sclk_lvl;
  assign full       = (cnt == FULL);

  assign clr   = frame_fall;
  assign shift = open_q & sclk_fall & ~frame_fall & ((mode_q == MODE_CHAIN) | ~full);

  assign load_solo  = open_q & (mode_q == MODE_SOLO) & full;
  assign load_chain = open_q & (mode_q == MODE_CHAIN) & frame_rise & full;
  assign load       = load_solo | load_chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b1;
      sclk_q  <= 1'b1;
      open_q  <= 1'b0;
      mode_q  <= MODE_CHAIN;
      upd     <= 1'b0;
      ctrl    <= '0;
      data    <= '0;
    end else begin
      frame_q <= frame_lvl;
      sclk_q  <= sclk_lvl;

      if (frame_fall)      open_q <= 1'b1;
      else if (load)       open_q <= 1'b0;
      else if (frame_rise) open_q <= 1'b0;

      upd <= load;
      if (load) begin
        ctrl <= word[WORD_W-1 -: CTRL_W];
        data <= word[DATA_W-1:0];
        if (word[WORD_W-1 -: CTRL_W] == SOLO_CODE) mode_q <= MODE_SOLO;
      end
    end
  end

  assign chain = (mode_q == MODE_CHAIN);
endmodule

// File: rtl/dacif_serial_rx.sv
module dacif_serial_rx
  import dacif_pkg::*;
#(
  parameter int               WORD_W      = 16,
  parameter int               CTRL_W      = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CTRL_W-1:0] SOLO_CODE  = SOLO_CODE_DEFAULT,
  localparam int              DATA_W      = WORD_W - CTRL_W,
  localparam int              CNT_W       = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_n,
  input  logic              ser_clk,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              upd_strobe,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic [DATA_W-1:0] data_out,
  output logic              chain_en
);
  logic [2:0]        lines;
  logic              clr, shift;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  cnt;

  dacif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({ser_in, ser_clk, frame_n}),
    .sync_out (lines)
  );

  dacif_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .shift (shift),
    .din   (lines[2]),
    .word  (word),
    .cnt   (cnt)
  );

  dacif_frame_ctl #(.WORD_W(WORD_W), .CTRL_W(CTRL_W), .SOLO_CODE(SOLO_CODE)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .frame_lvl (lines[0]),
    .sclk_lvl  (lines[1]),
    .word      (word),
    .cnt       (cnt),
    .clr       (clr),
    .shift     (shift),
    .upd       (upd_strobe),
    .ctrl      (ctrl_out),
    .data      (data_out),
    .chain     (chain_en)
  );

  assign ser_out = chain_en & word[WORD_W-1];
endmodule

// File: rtl/dacif_serial_rx_chk.sv
module dacif_serial_rx_chk #(
  parameter int               CTRL_W    = 4,
  parameter int               DATA_W    = 12,
  parameter logic [CTRL_W-1:0] SOLO_CODE = 4'b1001
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_out,
  input logic              upd_strobe,
  input logic [CTRL_W-1:0] ctrl_out,
  input logic [DATA_W-1:0] data_out,
  input logic              chain_en
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (chain_en && !upd_strobe && ctrl_out == '0 && data_out == '0 && !ser_out));

  assert_hold_without_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !upd_strobe |-> ($stable(ctrl_out) && $stable(data_out)));

  assert_quiet_out_solo_R8: assert property (@(posedge clk) disable iff (rst)
    !chain_en |-> !ser_out);

  assert_mode_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    !$rose(chain_en));

  assert_code_leaves_chain_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && ctrl_out == SOLO_CODE) |-> !chain_en);

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    upd_strobe |=> !upd_strobe);
endmodule

bind dacif_serial_rx dacif_serial_rx_chk #(
  .CTRL_W(CTRL_W), .DATA_W(DATA_W), .SOLO_CODE(SOLO_CODE)
) u_chk (.*);

// File: tb/dacif_serial_rx_test.sv
module dacif_serial_rx_test;
  localparam int HP = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n = 1'b1, ser_clk = 1'b1, ser_in = 1'b0;
  logic        ser_out, upd_strobe, chain_en;
  logic [3:0]  ctrl_out;
  logic [11:0] data_out;

  int vectors = 0, fails = 0, strobes = 0, wide = 0;
  bit done = 0;
  logic prev_upd = 1'b0;

  always #2.5 clk = ~clk;

  dacif_serial_rx uut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .ser_clk(ser_clk), .ser_in(ser_in),
    .ser_out(ser_out), .upd_strobe(upd_strobe), .ctrl_out(ctrl_out),
    .data_out(data_out), .chain_en(chain_en)
  );

  always @(negedge clk) begin
    if (upd_strobe) strobes++;
    if (upd_strobe && prev_upd) wide++;
    prev_upd = upd_strobe;
  end

  function automatic logic [3:0] f_ctrl(input logic [15:0] w);
    return w[15:12];
  endfunction

  function automatic logic [11:0] f_data(input logic [15:0] w);
    return w[11:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b, output logic seen);
    ser_in = b;
    wait_clk(HP);
    seen = ser_out;
    ser_clk = 1'b0;
    wait_clk(HP);
    ser_clk = 1'b1;
  endtask

  task automatic open_frame();
    frame_n = 1'b0;
    wait_clk(HP);
  endtask

  task automatic close_frame();
    wait_clk(HP);
    frame_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic send(input logic [15:0] w, input int nb);
    logic s;
    for (int i = 0; i < nb; i++) bit_out(w[15-i], s);
    wait_clk(HP);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int base;
    logic s;
    logic [15:0] wa, wb, w;
    logic [3:0] ec;
    logic [11:0] ed;
    void'($urandom(32'h5EED_0042));
    do_reset();

    // R1: reset state
    chk("R1 chain_en", chain_en, 1);
    chk("R1 ctrl", ctrl_out, 0);
    chk("R1 data", data_out, 0);
    chk("R1 ser_out", ser_out, 0);
    chk("R1 no strobe", strobes, 0);

    // R7/R2: chained mode, no capture before frame rises
    base = strobes;
    open_frame();
    send(16'h5A3C, 16);
    chk("R7 no capture at edge 16", strobes, base);
    chk("R7 ctrl held", ctrl_out, 0);
    close_frame();
    chk("R7 capture on rise", strobes, base + 1);
    chk("R2 ctrl field", ctrl_out, f_ctrl(16'h5A3C));
    chk("R2 data field", data_out, f_data(16'h5A3C));

    // R8: pass-through of the first word while the second shifts in
    wa = 16'h7123; wb = 16'h3456;
    open_frame();
    send(wa, 16);
    for (int i = 0; i < 16; i++) begin
      bit_out(wb[15-i], s);
      chk($sformatf("R8 ser_out bit %0d", i), s, wa[15-i]);
    end
    close_frame();
    chk("R7 last 16 bits captured", {ctrl_out, data_out}, wb);
    chk("R9 other code keeps chain", chain_en, 1);

    // R5: abort in chained mode
    base = strobes;
    open_frame();
    send(16'hFFFF, 10);
    close_frame();
    chk("R5 chain abort no strobe", strobes, base);
    chk("R5 chain abort holds", {ctrl_out, data_out}, wb);

    // R9: mode code
    open_frame();
    send(16'h9ABC, 16);
    close_frame();
    chk("R9 code clears chain", chain_en, 0);
    chk("R9 code frame captured", {ctrl_out, data_out}, 16'h9ABC);
    chk("R8 ser_out quiet solo", ser_out, 0);

    // R3/R4: standalone capture without frame rise, extra edges ignored
    base = strobes;
    open_frame();
    send(16'h2468, 16);
    wait_clk(4);
    chk("R3 capture at edge 16", strobes, base + 1);
    chk("R3 fields", {ctrl_out, data_out}, 16'h2468);
    send(16'hF800, 5);
    chk("R4 extra edges no strobe", strobes, base + 1);
    chk("R4 fields unchanged", {ctrl_out, data_out}, 16'h2468);
    close_frame();
    chk("R4 no strobe on rise", strobes, base + 1);

    // R5: abort in standalone mode
    open_frame();
    send(16'hFFFF, 7);
    close_frame();
    chk("R5 solo abort no strobe", strobes, base + 1);
    chk("R5 solo abort holds", {ctrl_out, data_out}, 16'h2468);

    // R6: aborted bits do not count toward the next frame
    open_frame();
    send(16'hAAAA, 10);
    close_frame();
    open_frame();
    send(16'h5555, 6);
    close_frame();
    chk("R6 short follow-up no strobe", strobes, base + 1);
    open_frame();
    send(16'h1357, 16);
    close_frame();
    chk("R6 full frame after abort", {ctrl_out, data_out}, 16'h1357);
    chk("R6 strobe count", strobes, base + 2);

    // R11: serial clock while frame high
    send(16'hFFFF, 16);
    wait_clk(6);
    chk("R11 idle edges no strobe", strobes, base + 2);
    chk("R11 idle edges hold", {ctrl_out, data_out}, 16'h1357);

    // Random standalone frames, some aborted
    ec = 4'h1; ed = 12'h357;
    for (int k = 0; k < 24; k++) begin
      int nb;
      w = 16'($urandom);
      nb = ($urandom % 4 == 0) ? 1 + int'($urandom % 15) : 16;
      base = strobes;
      open_frame();
      send(w, nb);
      close_frame();
      if (nb == 16) begin ec = f_ctrl(w); ed = f_data(w); end
      chk($sformatf("R3 random strobe %0d", k), strobes, base + (nb == 16 ? 1 : 0));
      chk($sformatf("R5 random fields %0d", k), {ctrl_out, data_out}, {ec, ed});
    end

    chk("R10 single-cycle strobes", wide, 0);

    // R9: only reset restores chained mode
    do_reset();
    chk("R9 reset restores chain", chain_en, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule